// File: doc/BRIEF.md
# Surface Coordinate Address Generator

This block turns the integer coordinates of one surface access into a linear byte offset within a pitch-linear surface. The caller supplies a dimension mode, up to three coordinate words, the element size, a byte-address flag, and the extents and pitches taken from an already decoded surface descriptor. The block decides which coordinate words take part and how each one is read: signed or unsigned, a full 32-bit spatial value or a 16-bit layer index, and an element index or a byte address. It then checks every active axis against its extent and applies the selected out-of-bounds policy.

In the same cycle the block splits a 32-bit binding word into a sampler index and a header index. It marks the access as invalid when the header index is above a programmed maximum. All results are registered and appear one cycle after an input is accepted. The caller uses the drop flag to suppress the memory operation, the trap flag to raise an error, and the offset to form the final address.

Top module: `surf_addr_gen`

## Requirements
- R1: When `in_valid` is high at a rising edge, the results appear on the outputs one cycle later, and `out_valid` is high for exactly that cycle. While `in_valid` is low, `out_valid` stays low and all other outputs keep their last values.
- R2: `smp_idx` equals bits 31:20 of `desc_word` and `hdr_idx` equals bits 19:0.
- R3: `hdr_invalid` is 1 when `hdr_idx` is strictly greater than `hdr_max`. An index equal to the maximum is valid.
- R4: `dim` codes are 0=1D, 1=1D buffer, 2=1D array, 3=2D, 4=2D array, 5=3D, and 6/7 behave as 1D. 1D and 1D buffer use x only. 1D array uses x and a layer taken from `coord_y`. 2D uses x and y. 2D array uses x, y and a layer taken from `coord_z`. 3D uses x, y and z. Unused words have no effect on any output.
- R5: The layer index uses only bits 15:0 of its word, read as unsigned. It is bounded by `ext_z` and scaled by `slice_pitch`.
- R6: The 1D buffer x coordinate is signed when `clamp` is nearest (1) and unsigned otherwise. Every other x, y and z coordinate is signed 32-bit.
- R7: The element size is 4 bytes when `esz_8`=0 and 8 bytes when `esz_8`=1. When `byte_addr`=0, x is an element index and contributes x×size bytes. When `byte_addr`=1, x is already a byte offset, and its element index (x divided by size, rounded toward minus infinity) is the value checked against `ext_x`.
- R8: When `byte_addr`=1 and x is not a multiple of the element size, both `misalign` and `drop` are 1.
- R9: `byte_off` = x_bytes + y×`row_pitch` + (z or layer)×`slice_pitch`, computed modulo 2^64. Coordinates are sign-extended according to R6, and the pitches are unsigned.
- R10: With `clamp`=1 (nearest), each active coordinate saturates to 0..extent-1 (to 0 when the extent is 0). No flag is raised, and x_bytes is the clamped element index × size.
- R11: With `clamp`=0 or 3 (ignore), any active coordinate below 0 or at least its extent sets `drop`=1 and `trap_err`=0. The offset is formed from the unclamped coordinates.
- R12: With `clamp`=2 (trap), an out-of-bounds coordinate sets `trap_err`=1. `drop` is then set only by misalignment. In every other mode `trap_err` is 0.
- R13: While `rst_n` is low, `out_valid`, `byte_off` and all flag and index outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the request on this edge |
| dim | input | 3 | Dimension mode code |
| clamp | input | 2 | Out-of-bounds policy code |
| byte_addr | input | 1 | x is a byte address |
| esz_8 | input | 1 | Element size 8 bytes (else 4) |
| coord_x | input | 32 | x coordinate word |
| coord_y | input | 32 | y coordinate or 1D array layer word |
| coord_z | input | 32 | z coordinate or 2D array layer word |
| ext_x | input | 32 | Width in elements |
| ext_y | input | 32 | Height in rows |
| ext_z | input | 32 | Depth or layer count |
| row_pitch | input | 32 | Bytes per row |
| slice_pitch | input | 32 | Bytes per slice or layer |
| desc_word | input | 32 | Packed sampler and header indices |
| hdr_max | input | 20 | Highest valid header index |
| out_valid | output | 1 | Result valid |
| byte_off | output | 64 | Linear byte offset |
| hdr_idx | output | 20 | Header index |
| smp_idx | output | 12 | Sampler index |
| hdr_invalid | output | 1 | Header index above maximum |
| drop | output | 1 | Access must not reach memory |
| trap_err | output | 1 | Out-of-bounds trap |
| misalign | output | 1 | Unaligned byte address |

## Verification
The bench builds the block with its default parameters: 32-bit coordinates and extents, a 20/12 split of the binding word, 16-bit layers and a 64-bit offset. At these widths the corners at the top of the 32-bit range can be reached directly. An x of 0x80000000 is negative in 1D but lies within a 0xFFFFFFFF-wide buffer, an all-ones buffer coordinate becomes a 34-bit byte value, and a negative x under trap yields a sign-extended 64-bit offset. These widths also make a zero extent under clamping, and layer words whose upper half must be discarded, simple to set up.

// File: rtl/surf_addr_pkg.sv
package surf_addr_pkg;

  typedef enum logic [2:0] {
    DIM_1D   = 3'd0,
    DIM_BUF  = 3'd1,
    DIM_1DA  = 3'd2,
    DIM_2D   = 3'd3,
    DIM_2DA  = 3'd4,
    DIM_3D   = 3'd5,
    DIM_RSV6 = 3'd6,
    DIM_RSV7 = 3'd7
  } dim_e;

  typedef enum logic [1:0] {
    OOB_IGNORE  = 2'd0,
    OOB_NEAREST = 2'd1,
    OOB_TRAP    = 2'd2,
    OOB_IGN_ALT = 2'd3
  } oob_mode_e;

  localparam int NUM_AXES = 3;

endpackage

// File: rtl/surf_desc_unpack.sv
module surf_desc_unpack #(
  parameter int HDR_W = 20,
  parameter int SMP_W = 12
) (
  input  logic [HDR_W+SMP_W-1:0] desc_word,
  input  logic [HDR_W-1:0]       hdr_max,
  output logic [HDR_W-1:0]       hdr_idx,
  output logic [SMP_W-1:0]       smp_idx,
  output logic                   hdr_invalid
);

  localparam int DESC_W = HDR_W + SMP_W;

  always_comb begin
    hdr_idx     = desc_word[HDR_W-1:0];
    smp_idx     = desc_word[DESC_W-1:HDR_W];
    hdr_invalid = (hdr_idx > hdr_max);
  end

endmodule

// File: rtl/surf_axis_bound.sv
module surf_axis_bound #(
  parameter int VAL_W = 34,
  parameter int EXT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    nearest,
  input  logic signed [VAL_W-1:0] val,
  input  logic [EXT_W-1:0]        extent,
  output logic                    oob,
  output logic signed [VAL_W-1:0] pos
);

  localparam int PAD_W = VAL_W - EXT_W;

  logic signed [VAL_W-1:0] ext_s;
  logic signed [VAL_W-1:0] hi_s;
  logic                    below;
  logic                    above;

  always_comb begin
    ext_s = $signed({{PAD_W{1'b0}}, extent});
    hi_s  = (extent == '0) ? '0 : (ext_s - 1);
    below = (val < 0);
    above = (val >= ext_s);
    oob   = active & (below | above);
    if (!active) begin
      pos = '0;
    end else if (nearest && below) begin
      pos = '0;
    end else if (nearest && above) begin
      pos = hi_s;
    end else begin
      pos = val;
    end
  end

  // R10: a clamped coordinate always lies inside the surface
  assert_clamp_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && nearest) |-> ((pos >= 0) &&
      ((extent == '0) ? (pos == '0) : (pos < ext_s))));

  // R9: an in-range coordinate passes through unchanged and is not flagged
  assert_inrange_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (val >= 0) && (val < ext_s)) |-> (!oob && (pos == val)));

endmodule

// File: rtl/surf_offset_calc.sv
module surf_offset_calc #(
  parameter int VAL_W   = 34,
  parameter int PITCH_W = 32,
  parameter int OFF_W   = 64
) (
  input  logic                    nearest,
  input  logic                    byte_addr,
  input  logic                    esz_8,
  input  logic signed [VAL_W-1:0] x_raw,
  input  logic signed [VAL_W-1:0] x_pos,
  input  logic signed [VAL_W-1:0] y_pos,
  input  logic signed [VAL_W-1:0] z_pos,
  input  logic [PITCH_W-1:0]      row_pitch,
  input  logic [PITCH_W-1:0]      slice_pitch,
  output logic [OFF_W-1:0]        byte_off
);

  localparam int EXT_PAD = OFF_W - VAL_W;
  localparam int PIT_PAD = OFF_W - PITCH_W;

  function automatic logic [OFF_W-1:0] sext(input logic [VAL_W-1:0] v);
    return {{EXT_PAD{v[VAL_W-1]}}, v};
  endfunction

  logic [OFF_W-1:0] x_term;
  logic [OFF_W-1:0] y_term;
  logic [OFF_W-1:0] z_term;
  logic [OFF_W-1:0] rp_w;
  logic [OFF_W-1:0] sp_w;

  always_comb begin
    rp_w = {{PIT_PAD{1'b0}}, row_pitch};
    sp_w = {{PIT_PAD{1'b0}}, slice_pitch};
    if (byte_addr && !nearest) begin
      x_term = sext(x_raw);
    end else if (esz_8) begin
      x_term = sext(x_pos) << 3;
    end else begin
      x_term = sext(x_pos) << 2;
    end
    y_term   = sext(y_pos) * rp_w;
    z_term   = sext(z_pos) * sp_w;
    byte_off = x_term + y_term + z_term;
  end

endmodule

// File: rtl/surf_addr_gen.sv
module surf_addr_gen
  import surf_addr_pkg::*;
#(
  parameter int COORD_W = 32,
  parameter int EXT_W   = 32,
  parameter int PITCH_W = 32,
  parameter int LAYER_W = 16,
  parameter int HDR_W   = 20,
  parameter int SMP_W   = 12,
  parameter int OFF_W   = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [2:0]               dim,
  input  logic [1:0]               clamp,
  input  logic                     byte_addr,
  input  logic                     esz_8,
  input  logic [COORD_W-1:0]       coord_x,
  input  logic [COORD_W-1:0]       coord_y,
  input  logic [COORD_W-1:0]       coord_z,
  input  logic [EXT_W-1:0]         ext_x,
  input  logic [EXT_W-1:0]         ext_y,
  input  logic [EXT_W-1:0]         ext_z,
  input  logic [PITCH_W-1:0]       row_pitch,
  input  logic [PITCH_W-1:0]       slice_pitch,
  input  logic [HDR_W+SMP_W-1:0]   desc_word,
  input  logic [HDR_W-1:0]         hdr_max,
  output logic                     out_valid,
  output logic [OFF_W-1:0]         byte_off,
  output logic [HDR_W-1:0]         hdr_idx,
  output logic [SMP_W-1:0]         smp_idx,
  output logic                     hdr_invalid,
  output logic                     drop,
  output logic                     trap_err,
  output logic                     misalign
);

  localparam int VAL_W    = COORD_W + 2;
  localparam int XPAD_W   = VAL_W - COORD_W;
  localparam int LPAD_W   = VAL_W - LAYER_W;

  dim_e      dim_m;
  oob_mode_e mode_m;
  logic      nearest;
  logic      x_signed;
  logic      y_act;
  logic      z_act;
  logic      z_is_layer;
  logic [LAYER_W-1:0] layer_word;

  logic signed [VAL_W-1:0] x_ext;
  logic signed [VAL_W-1:0] ax_val [NUM_AXES];
  logic [EXT_W-1:0]        ax_ext [NUM_AXES];
  logic                    ax_act [NUM_AXES];
  logic                    ax_oob [NUM_AXES];
  logic signed [VAL_W-1:0] ax_pos [NUM_AXES];

  logic             oob_any;
  logic             misalign_d;
  logic             drop_d;
  logic             trap_d;
  logic [OFF_W-1:0] off_d;
  logic [HDR_W-1:0] hdr_d;
  logic [SMP_W-1:0] smp_d;
  logic             hinv_d;

  // Mode decode
  always_comb begin
    dim_m   = dim_e'(dim);
    mode_m  = oob_mode_e'(clamp);
    nearest = (mode_m == OOB_NEAREST);
    x_signed   = !((dim_m == DIM_BUF) && !nearest);
    y_act      = 1'b0;
    z_act      = 1'b0;
    z_is_layer = 1'b0;
    layer_word = coord_z[LAYER_W-1:0];
    case (dim_m)
      DIM_1DA: begin
        z_act      = 1'b1;
        z_is_layer = 1'b1;
        layer_word = coord_y[LAYER_W-1:0];
      end
      DIM_2D:  y_act = 1'b1;
      DIM_2DA: begin
        y_act      = 1'b1;
        z_act      = 1'b1;
        z_is_layer = 1'b1;
      end
      DIM_3D: begin
        y_act = 1'b1;
        z_act = 1'b1;
      end
      default: ;
    endcase
  end

  // Coordinate widening and element-index formation
  always_comb begin
    x_ext = $signed({{XPAD_W{x_signed & coord_x[COORD_W-1]}}, coord_x});
    if (byte_addr) begin
      ax_val[0]  = esz_8 ? (x_ext >>> 3) : (x_ext >>> 2);
      misalign_d = esz_8 ? (coord_x[2:0] != 3'd0) : (coord_x[1:0] != 2'd0);
    end else begin
      ax_val[0]  = x_ext;
      misalign_d = 1'b0;
    end
    ax_val[1] = $signed({{XPAD_W{coord_y[COORD_W-1]}}, coord_y});
    if (z_is_layer) begin
      ax_val[2] = $signed({{LPAD_W{1'b0}}, layer_word});
    end else begin
      ax_val[2] = $signed({{XPAD_W{coord_z[COORD_W-1]}}, coord_z});
    end
    ax_ext[0] = ext_x;
    ax_ext[1] = ext_y;
    ax_ext[2] = ext_z;
    ax_act[0] = 1'b1;
    ax_act[1] = y_act;
    ax_act[2] = z_act;
  end

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    surf_axis_bound #(
      .VAL_W (VAL_W),
      .EXT_W (EXT_W)
    ) axis_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (ax_act[a]),
      .nearest (nearest),
      .val     (ax_val[a]),
      .extent  (ax_ext[a]),
      .oob     (ax_oob[a]),
      .pos     (ax_pos[a])
    );
  end

  surf_offset_calc #(
    .VAL_W   (VAL_W),
    .PITCH_W (PITCH_W),
    .OFF_W   (OFF_W)
  ) offset_i (
    .nearest     (nearest),
    .byte_addr   (byte_addr),
    .esz_8       (esz_8),
    .x_raw       (x_ext),
    .x_pos       (ax_pos[0]),
    .y_pos       (ax_pos[1]),
    .z_pos       (ax_pos[2]),
    .row_pitch   (row_pitch),
    .slice_pitch (slice_pitch),
    .byte_off    (off_d)
  );

  surf_desc_unpack #(
    .HDR_W (HDR_W),
    .SMP_W (SMP_W)
  ) desc_i (
    .desc_word   (desc_word),
    .hdr_max     (hdr_max),
    .hdr_idx     (hdr_d),
    .smp_idx     (smp_d),
    .hdr_invalid (hinv_d)
  );

  // Policy
  always_comb begin
    oob_any = ax_oob[0] | ax_oob[1] | ax_oob[2];
    trap_d  = oob_any && (mode_m == OOB_TRAP);
    drop_d  = misalign_d ||
              (oob_any && ((mode_m == OOB_IGNORE) || (mode_m == OOB_IGN_ALT)));
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      byte_off    <= '0;
      hdr_idx     <= '0;
      smp_idx     <= '0;
      hdr_invalid <= 1'b0;
      drop        <= 1'b0;
      trap_err    <= 1'b0;
      misalign    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        byte_off    <= off_d;
        hdr_idx     <= hdr_d;
        smp_idx     <= smp_d;
        hdr_invalid <= hinv_d;
        drop        <= drop_d;
        trap_err    <= trap_d;
        misalign    <= misalign_d;
      end
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(byte_off) && $stable(drop)));

  assert_hdr_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (hdr_invalid == (hdr_idx > $past(hdr_max))));

  assert_misalign_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && misalign) |-> drop);

  assert_elem_never_misaligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !byte_addr) |=> !misalign);

  assert_trap_only_in_trap_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (clamp != 2'd2)) |=> !trap_err);

endmodule

// File: tb/surf_addr_gen_tb_top.sv
`timescale 1ns/1ps
module surf_addr_gen_tb_top;

  typedef struct packed {
    logic [2:0]  dim;
    logic [1:0]  cl;
    logic        ba;
    logic        e8;
    logic [31:0] cx;
    logic [31:0] cy;
    logic [31:0] cz;
    logic [31:0] ex;
    logic [31:0] ey;
    logic [31:0] ez;
    logic [31:0] desc;
    logic [19:0] hmax;
    logic [63:0] off;
    logic        drp;
    logic        trp;
    logic        mis;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam logic [31:0] RP = 32'd256;
  localparam logic [31:0] SP = 32'd4096;
  localparam logic [31:0] DD = 32'hABC0_0005;

  localparam vec_t VECS [NV] = '{
    // R4 R7: 1D element index, y/z words ignored
    '{3'd0, 2'd0, 1'b0, 1'b0, 32'd3, 32'd7, 32'd9, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd12, 1'b0, 1'b0, 1'b0, 8'd7},
    // R7: 8-byte elements
    '{3'd0, 2'd0, 1'b0, 1'b1, 32'd5, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd40, 1'b0, 1'b0, 1'b0, 8'd7},
    // R7: byte address, aligned
    '{3'd0, 2'd0, 1'b1, 1'b0, 32'd12, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd12, 1'b0, 1'b0, 1'b0, 8'd7},
    // R8: byte address 12 not a multiple of 8
    '{3'd0, 2'd0, 1'b1, 1'b1, 32'd12, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd12, 1'b1, 1'b0, 1'b1, 8'd8},
    // R9: 2D
    '{3'd3, 2'd0, 1'b0, 1'b0, 32'd2, 32'd3, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd776, 1'b0, 1'b0, 1'b0, 8'd9},
    // R9: 3D
    '{3'd5, 2'd0, 1'b0, 1'b1, 32'd1, 32'd2, 32'd3, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd12808, 1'b0, 1'b0, 1'b0, 8'd9},
    // R5: 2D array, layer from low half of z word
    '{3'd4, 2'd0, 1'b0, 1'b0, 32'd0, 32'd1, 32'h0003_0002, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd8448, 1'b0, 1'b0, 1'b0, 8'd5},
    // R5: 1D array, layer from low half of y word
    '{3'd2, 2'd0, 1'b0, 1'b0, 32'd4, 32'hFFFF_0001, 32'd99, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd4112, 1'b0, 1'b0, 1'b0, 8'd5},
    // R10: nearest clamps x low, y high
    '{3'd3, 2'd1, 1'b0, 1'b0, 32'hFFFF_FFFB, 32'd70, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd12544, 1'b0, 1'b0, 1'b0, 8'd10},
    // R11: ignore, x == extent
    '{3'd3, 2'd0, 1'b0, 1'b0, 32'd100, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd400, 1'b1, 1'b0, 1'b0, 8'd11},
    // R12: trap, x = -1
    '{3'd3, 2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b1, 1'b0, 8'd12},
    // R6: buffer under nearest is signed
    '{3'd1, 2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd0, 1'b0, 1'b0, 1'b0, 8'd6},
    // R6: buffer under ignore is unsigned
    '{3'd1, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'h3_FFFF_FFFC, 1'b1, 1'b0, 1'b0, 8'd6},
    // R6: unsigned buffer within a huge extent
    '{3'd1, 2'd2, 1'b0, 1'b0, 32'h8000_0000, 32'd0, 32'd0, 32'hFFFF_FFFF, 32'd50, 32'd10, DD, 20'h10, 64'h2_0000_0000, 1'b0, 1'b0, 1'b0, 8'd6},
    // R6: same word in 1D is negative and traps
    '{3'd0, 2'd2, 1'b0, 1'b0, 32'h8000_0000, 32'd0, 32'd0, 32'hFFFF_FFFF, 32'd50, 32'd10, DD, 20'h10, 64'hFFFF_FFFE_0000_0000, 1'b0, 1'b1, 1'b0, 8'd6},
    // R3: header equal to maximum is valid
    '{3'd0, 2'd0, 1'b0, 1'b0, 32'd1, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, 32'h0010_0010, 20'h10, 64'd4, 1'b0, 1'b0, 1'b0, 8'd3},
    // R3: header one above maximum
    '{3'd0, 2'd0, 1'b0, 1'b0, 32'd1, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, 32'h7FF0_0011, 20'h10, 64'd4, 1'b0, 1'b0, 1'b0, 8'd3},
    // R11: clamp code 3 acts as ignore
    '{3'd3, 2'd3, 1'b0, 1'b0, 32'd0, 32'd50, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd12800, 1'b1, 1'b0, 1'b0, 8'd11},
    // R10: zero extent clamps to 0
    '{3'd0, 2'd1, 1'b0, 1'b0, 32'd7, 32'd0, 32'd0, 32'd0, 32'd50, 32'd10, DD, 20'h10, 64'd0, 1'b0, 1'b0, 1'b0, 8'd10},
    // R10: byte address clamped to last element
    '{3'd0, 2'd1, 1'b1, 1'b1, 32'd1000, 32'd0, 32'd0, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd792, 1'b0, 1'b0, 1'b0, 8'd10},
    // R4: reserved dim 7 behaves as 1D
    '{3'd7, 2'd0, 1'b0, 1'b0, 32'd2, 32'd5, 32'd5, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd8, 1'b0, 1'b0, 1'b0, 8'd4},
    // R5: layer equal to layer count is out of range
    '{3'd4, 2'd0, 1'b0, 1'b0, 32'd0, 32'd0, 32'h1234_000A, 32'd100, 32'd50, 32'd10, DD, 20'h10, 64'd40960, 1'b1, 1'b0, 1'b0, 8'd5}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  dim;
  logic [1:0]  clamp;
  logic        byte_addr;
  logic        esz_8;
  logic [31:0] coord_x, coord_y, coord_z;
  logic [31:0] ext_x, ext_y, ext_z;
  logic [31:0] row_pitch, slice_pitch;
  logic [31:0] desc_word;
  logic [19:0] hdr_max;
  logic        out_valid;
  logic [63:0] byte_off;
  logic [19:0] hdr_idx;
  logic [11:0] smp_idx;
  logic        hdr_invalid, drop, trap_err, misalign;

  int errs;
  int checks;
  bit done;

  surf_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dim(dim), .clamp(clamp),
    .byte_addr(byte_addr), .esz_8(esz_8), .coord_x(coord_x), .coord_y(coord_y),
    .coord_z(coord_z), .ext_x(ext_x), .ext_y(ext_y), .ext_z(ext_z),
    .row_pitch(row_pitch), .slice_pitch(slice_pitch), .desc_word(desc_word),
    .hdr_max(hdr_max), .out_valid(out_valid), .byte_off(byte_off),
    .hdr_idx(hdr_idx), .smp_idx(smp_idx), .hdr_invalid(hdr_invalid),
    .drop(drop), .trap_err(trap_err), .misalign(misalign)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid  = 1'b1;
    dim       = v.dim;
    clamp     = v.cl;
    byte_addr = v.ba;
    esz_8     = v.e8;
    coord_x   = v.cx;
    coord_y   = v.cy;
    coord_z   = v.cz;
    ext_x     = v.ex;
    ext_y     = v.ey;
    ext_z     = v.ez;
    desc_word = v.desc;
    hdr_max   = v.hmax;
  endtask

  task automatic check_zero(input string req);
    chk(req, "out_valid", {63'd0, out_valid}, 64'd0);
    chk(req, "byte_off", byte_off, 64'd0);
    chk(req, "flags", {60'd0, hdr_invalid, drop, trap_err, misalign}, 64'd0);
    chk(req, "indices", {32'd0, smp_idx, hdr_idx}, 64'd0);
  endtask

  initial begin
    errs = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; dim = '0; clamp = '0; byte_addr = 1'b0;
    esz_8 = 1'b0; coord_x = '0; coord_y = '0; coord_z = '0;
    ext_x = '0; ext_y = '0; ext_z = '0;
    row_pitch = RP; slice_pitch = SP; desc_word = '0; hdr_max = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_zero("R13");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      vec_t v;
      v = VECS[i];
      rq = $sformatf("R%0d#%0d", v.req, i);
      drive(v);
      @(negedge clk);
      chk("R1", "out_valid", {63'd0, out_valid}, 64'd1);
      chk(rq, "byte_off", byte_off, v.off);
      chk(rq, "drop", {63'd0, drop}, {63'd0, v.drp});
      chk(rq, "trap_err", {63'd0, trap_err}, {63'd0, v.trp});
      chk(rq, "misalign", {63'd0, misalign}, {63'd0, v.mis});
      chk("R2", "hdr_idx", {44'd0, hdr_idx}, {44'd0, v.desc[19:0]});
      chk("R2", "smp_idx", {52'd0, smp_idx}, {52'd0, v.desc[31:20]});
      chk("R3", "hdr_invalid", {63'd0, hdr_invalid},
          {63'd0, (v.desc[19:0] > v.hmax)});
    end

    // R1: idle cycles hold results even as inputs change
    in_valid = 1'b0;
    coord_x = 32'd55; coord_y = 32'd1; dim = 3'd3; clamp = 2'd2;
    desc_word = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R1", "out_valid idle", {63'd0, out_valid}, 64'd0);
    chk("R1", "byte_off hold", byte_off, VECS[NV-1].off);
    chk("R1", "drop hold", {63'd0, drop}, 64'd1);
    @(negedge clk);
    chk("R1", "hdr_idx hold", {44'd0, hdr_idx}, {44'd0, VECS[NV-1].desc[19:0]});
    chk("R1", "trap hold", {63'd0, trap_err}, 64'd0);

    // R13: asynchronous reset clears held results without a clock edge
    drive(VECS[10]);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12", "trap before reset", {63'd0, trap_err}, 64'd1);
    #3 rst_n = 1'b0;
    #2;
    check_zero("R13");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "out_valid after release", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule